// File: doc/BRIEF.md
# Nibble-Multiplexed Multiplier Display

This block multiplies two small unsigned numbers set on a bank of six switches and shows the result on a single seven-segment digit. Each factor arrives as three switch bits and is widened to four bits by a zero in the top position. Both factors are captured in registers on every clock edge. An array of single-bit full adders, arranged as shift-and-add rows of 4-bit ripple adders, forms the 8-bit product.

Only one digit is available, so the product is shown one hexadecimal nibble at a time. The lower nibble appears first, with the dot lit. After a fixed dwell the upper nibble replaces it, with the dot dark. The two phases then keep alternating. With the default dwell of 1250 cycles and a 2500 Hz clock, each nibble stays on the digit for half a second. Dividing the board oscillator down to that clock and debouncing the switches are handled outside the block.

Top module: `nibble_mux_mult`

## Requirements
- R1: Each factor is its 3-bit switch value with a zero added as bit 3, so every product lies in 0..49 and the upper nibble never exceeds 3.
- R2: Switch values are registered on every rising clock edge, and the digit reflects them only after that edge. A switch change made between edges does not alter the digit before the next edge.
- R3: The internal 8-bit product always equals the arithmetic product of the two registered factors.
- R4: In the low phase, `dot` is 1 and `seg` shows product bits 3..0.
- R5: In the high phase, `dot` is 0 and `seg` shows product bits 7..4.
- R6: Each phase lasts exactly DWELL clock cycles (default 1250), after which the other phase follows. Low and high alternate for as long as reset stays low.
- R7: Reset is synchronous and active high. It clears both factor registers, so the digit shows 0. It selects the low phase and restarts the dwell count, so the first low phase after release again lasts DWELL cycles.
- R8: Segments are active high, with seg[0]=a through seg[6]=g. The patterns are given as {g..a} in hex per nibble value: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71.
- R9: A factor change in the middle of a phase updates the digit after one edge, without moving the phase boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock (2500 Hz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| sw_a | input | 3 | Switch bits of the first factor |
| sw_b | input | 3 | Switch bits of the second factor |
| seg | output | 7 | Segment lines a..g, active high |
| dot | output | 1 | High while the lower nibble is shown |

## Verification
Several properties are checked on every cycle:
- The product equals the registered factors multiplied.
- The registers hold the zero-padded switch values from the previous edge.
- The dot holds steady until the dwell count completes and flips exactly then.
- Reset forces the low phase with a blank-zero digit.
- The digit is never dark.

Only the bench scenarios can show the rest. These include the full sweep of all 64 factor pairs in both phases against the hexadecimal segment patterns, the measured phase lengths, the one-edge latency of a switch change, and the recovery after a reset applied in the high phase.

// File: rtl/nmd_pkg.sv
package nmd_pkg;

    localparam int SW_W   = 3;
    localparam int FACT_W = 4;
    localparam int PROD_W = 2 * FACT_W;
    localparam int NIB_W  = 4;
    localparam int SEG_W  = 7;
    localparam int DWELL_DEFAULT = 1250;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic [FACT_W-1:0] a;
        logic [FACT_W-1:0] b;
    } factors_t;

    function automatic logic [FACT_W-1:0] pad_factor(input logic [SW_W-1:0] sw);
        return {{(FACT_W-SW_W){1'b0}}, sw};
    endfunction

    // Hexadecimal glyphs, bit 0 = segment a ... bit 6 = segment g.
    function automatic logic [SEG_W-1:0] hex_glyph(input logic [NIB_W-1:0] v);
        logic [SEG_W-1:0] g;
        case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/nmd_full_adder.sv
module nmd_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic xy;

    assign xy = x ^ y;
    assign s  = xy ^ ci;
    assign co = (x & y) | (xy & ci);
endmodule

// File: rtl/nmd_ripple_add.sv
module nmd_ripple_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        nmd_full_adder u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (carry[i]),
            .s  (sum[i]),
            .co (carry[i+1])
        );
    end

    assign co = carry[W];
endmodule

// File: rtl/nmd_array_mult.sv
module nmd_array_mult #(
    parameter int W = 4
) (
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod
);
    // Row r holds the running sum after adding partial product r.
    logic [W-1:0][W-1:0] row_sum;
    logic [W-1:0]        row_co;

    assign row_sum[0] = mcand & {W{mplier[0]}};
    assign row_co[0]  = 1'b0;
    assign prod[0]    = row_sum[0][0];

    for (genvar r = 1; r < W; r++) begin : g_row
        logic [W-1:0] shifted;
        logic [W-1:0] partial;

        assign shifted = {row_co[r-1], row_sum[r-1][W-1:1]};
        assign partial = mcand & {W{mplier[r]}};

        nmd_ripple_add #(.W(W)) u_add (
            .x   (shifted),
            .y   (partial),
            .sum (row_sum[r]),
            .co  (row_co[r])
        );

        assign prod[r] = row_sum[r][0];
    end

    assign prod[2*W-1:W] = {row_co[W-1], row_sum[W-1][W-1:1]};
endmodule

// File: rtl/nmd_phase_timer.sv
module nmd_phase_timer
    import nmd_pkg::*;
#(
    parameter int DWELL = DWELL_DEFAULT
) (
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);
    localparam int CNT_W = (DWELL > 2) ? $clog2(DWELL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= PH_LOW;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            phase <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nibble_mux_mult.sv
module nibble_mux_mult
    import nmd_pkg::*;
#(
    parameter int DWELL = DWELL_DEFAULT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sw_a,
    input  logic [2:0] sw_b,
    output logic [6:0] seg,
    output logic       dot
);
    factors_t          fq;
    logic [PROD_W-1:0] prod;
    phase_e            phase;
    logic [NIB_W-1:0]  nib;

    always_ff @(posedge clk) begin
        if (rst) begin
            fq <= '0;
        end else begin
            fq.a <= pad_factor(sw_a);
            fq.b <= pad_factor(sw_b);
        end
    end

    nmd_array_mult #(.W(FACT_W)) u_mult (
        .mcand  (fq.a),
        .mplier (fq.b),
        .prod   (prod)
    );

    nmd_phase_timer #(.DWELL(DWELL)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    always_comb begin
        case (phase)
            PH_LOW:  nib = prod[NIB_W-1:0];
            default: nib = prod[PROD_W-1:NIB_W];
        endcase
    end

    assign seg = hex_glyph(nib);
    assign dot = (phase == PH_LOW);
endmodule

// File: rtl/nmd_checker.sv
module nmd_checker #(
    parameter int DWELL = 1250
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] sw_a,
    input logic [2:0] sw_b,
    input logic [3:0] fa,
    input logic [3:0] fb,
    input logic [7:0] prod,
    input logic [6:0] seg,
    input logic       dot
);
    localparam int HW = $clog2(DWELL) + 1;

    logic [HW-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)                        held <= '0;
        else if (held == HW'(DWELL-1))  held <= '0;
        else                            held <= held + 1'b1;
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fa == {1'b0, $past(sw_a)}) && (fb == {1'b0, $past(sw_b)}));

    a_r3_product: assert property (@(posedge clk) disable iff (rst)
        prod == 8'(fa * fb));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (held != HW'(DWELL-1)) |=> $stable(dot));

    a_r6_flip: assert property (@(posedge clk) disable iff (rst)
        (held == HW'(DWELL-1)) |=> (dot != $past(dot)));

    a_r7_reset: assert property (@(posedge clk)
        rst |=> (dot && seg == 7'h3F));

    a_r8_lit: assert property (@(posedge clk) disable iff (rst)
        $countones(seg) >= 2);
endmodule

bind nibble_mux_mult nmd_checker #(.DWELL(DWELL)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .sw_a (sw_a),
    .sw_b (sw_b),
    .fa   (fq.a),
    .fb   (fq.b),
    .prod (prod),
    .seg  (seg),
    .dot  (dot)
);

// File: tb/nibble_mux_mult_tb.sv
module nibble_mux_mult_tb;
    localparam int DWELL = 1250;
    localparam int LIMIT = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sw_a = '0;
    logic [2:0] sw_b = '0;
    logic [6:0] seg;
    logic       dot;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int mcnt = 0;
    bit mhigh = 0;

    always #10 clk = ~clk;

    nibble_mux_mult u_dut (
        .clk  (clk),
        .rst  (rst),
        .sw_a (sw_a),
        .sw_b (sw_b),
        .seg  (seg),
        .dot  (dot)
    );

    // Phase model from R6/R7.
    always @(posedge clk) begin
        if (rst) begin
            mcnt  <= 0;
            mhigh <= 0;
        end else if (mcnt == DWELL - 1) begin
            mcnt  <= 0;
            mhigh <= !mhigh;
        end else begin
            mcnt <= mcnt + 1;
        end
    end

    function automatic logic [6:0] glyph(input int v);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[v & 15];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_digit(input string req, input int a, input int b);
        int p;
        p = a * b;
        chk(req, seg, glyph(mhigh ? (p >> 4) : p));
        chk(req, dot, mhigh ? 0 : 1);
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                sw_a = 3'(a);
                sw_b = 3'(b);
                @(posedge clk);
                @(negedge clk);
                check_digit(req, a, b);
            end
        end
    endtask

    task automatic measure_phase(input string req);
        int n;
        logic d0;
        n = 0;
        d0 = dot;
        while (dot == d0 && n < 3 * DWELL) begin
            @(negedge clk);
            n++;
        end
        chk(req, n, DWELL);
    endtask

    initial begin
        #(20 * LIMIT);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        sw_a = 3'd6;
        sw_b = 3'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset digit", seg, 7'h3F);
        chk("R7 reset dot", dot, 1);
        rst = 1'b0;

        // R2: change between edges, digit keeps the old value until the next edge
        @(posedge clk);
        @(negedge clk);
        chk("R2 first capture", seg, glyph(30));
        sw_a = 3'd3;
        sw_b = 3'd3;
        #1;
        chk("R2 no change before edge", seg, glyph(30));
        @(posedge clk);
        @(negedge clk);
        chk("R2 change after edge", seg, glyph(9));

        // R1 R3 R4 R8 R9: all factor pairs in the low phase
        sweep("R4 R3 R8 low sweep");

        while (!mhigh) @(negedge clk);
        // R5 R1 R9: all pairs in the high phase (upper nibble <= 3 for R1)
        sweep("R5 R1 R9 high sweep");

        // R6: measure two complete phases
        sw_a = 3'd7;
        sw_b = 3'd7;
        while (dot == 1'b0) @(negedge clk);
        measure_phase("R6 low length");
        check_digit("R5 R1 high after 7x7", 7, 7);
        measure_phase("R6 high length");
        check_digit("R4 low after 7x7", 7, 7);

        // R7: reset during the high phase
        while (dot == 1'b1) @(negedge clk);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R7 mid reset digit", seg, 7'h3F);
        chk("R7 mid reset dot", dot, 1);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7 recovery digit", seg, glyph(49));
        // After release, the low phase must last the full dwell again.
        begin
            int n;
            n = 1;
            while (dot == 1'b1 && n < 3 * DWELL) begin
                @(negedge clk);
                n++;
            end
            chk("R7 R6 low length after reset", n, DWELL);
        end
        check_digit("R9 R5 high after reset", 7, 7);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule